// File: doc/BRIEF.md
# Tape Playback Control Register and Mode Logic

This block keeps the control state of a two-channel cassette playback processor. A serial-bus front end, outside this block, hands it write bytes one at a time together with a strobe that marks the start of each bus frame. The block checks the device address, stores one byte of switch settings and one six-bit code, and drives the effective switch outputs: which tape head input is active, the equalization time constant, noise reduction, mute, the music-search mode, the amplifier gain code and one offset code per channel.

The outputs are not plain copies of the stored bits. When a search mode is running, noise reduction is held off and the short equalization constant is used. Two optional board pins can take over head selection and equalization. A direct jump between the two search modes is refused, so that the detector's internal latch is always cleared by passing through a non-search mode. The monitor bit in the settings byte changes what the second data byte means and sends the chosen channel's offset comparator to the detector output.

Top module: `tape_ctrl_regs`

## Requirements
- R1: After reset the settings byte is 8'h08 (noise reduction on, mute off, head input 2, 70 us, search off, monitor off), the gain code is 32 and both offset codes are 0.
- R2: The first byte after `frame_start` is the address. The frame is accepted only when bits 7:1 equal DEV_ADDR (default 7'h5C) and bit 0 is 0. Bytes of a rejected frame, and bytes seen before any `frame_start`, change nothing.
- R3: The second byte of an accepted frame is the settings byte: bit 7 monitor, bit 6 monitor channel (0 = A, 1 = B), bits 5:4 search mode, bit 3 noise reduction, bit 2 mute, bit 1 head (1 = input 1), bit 0 equalization (1 = 120 us). It shows on the outputs in the cycle after the byte is taken.
- R4: With monitor bit 0, bits 5:0 of the third byte become the gain code.
- R5: With monitor bit 1, bits 5:0 of the third byte become the offset code of the channel named by the monitor channel bit. The gain and the other channel's offset stay unchanged.
- R6: Bytes after the third one in a frame are ignored. A frame cut short keeps the bytes it fully delivered. No output code changes in a cycle without a byte.
- R7: Search mode 2'b00 is off, 2'b01 blank skip, 2'b10 latch search and 2'b11 scan search. A request for one search mode while the other one is active leaves the mode unchanged, while the other settings bits are still written. Passing through 2'b00 or 2'b01 makes the change possible.
- R8: While the search mode has bit 1 set, `nr_en` is 0 and `eq_long` is 0, whatever is stored and whatever the pins show.
- R9: `head_in1` follows `head_pin` when `head_pin_drv` is 1, and follows the stored head bit otherwise.
- R10: Outside a search mode, `eq_long` follows `eq_pin` when `eq_pin_drv` is 1, and follows the stored equalization bit otherwise.
- R11: `det_out` shows `ofs_cmp_b` when the monitor bit is 1 and the monitor channel is B, shows `ofs_cmp_a` when the monitor bit is 1 and the channel is A, and shows `det_pause` when the monitor bit is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| frame_start | input | 1 | One-cycle strobe at the start of a bus frame |
| byte_valid | input | 1 | A received byte is on byte_data |
| byte_data | input | 8 | Received byte |
| head_pin | input | 1 | Head override pin level (1 = input 1) |
| head_pin_drv | input | 1 | Head override pin is driven |
| eq_pin | input | 1 | Equalization override pin level (1 = 120 us) |
| eq_pin_drv | input | 1 | Equalization override pin is driven |
| det_pause | input | 1 | Music/pause detector result |
| ofs_cmp_a | input | 1 | Offset comparator, channel A |
| ofs_cmp_b | input | 1 | Offset comparator, channel B |
| head_in1 | output | 1 | Head input 1 selected |
| eq_long | output | 1 | 120 us equalization selected |
| nr_en | output | 1 | Noise reduction enabled |
| mute_en | output | 1 | Mute active |
| search_mode | output | 2 | Active search mode |
| gain_code | output | 6 | Amplifier gain code |
| offset_a | output | 6 | Offset code, channel A |
| offset_b | output | 6 | Offset code, channel B |
| det_out | output | 1 | Detector output pin value |

## Verification
On every cycle the assertions check the forcing done by a search mode, that the override pins win when driven, that latch and scan never follow each other directly, that no code moves without a byte, and that a byte moves at most one code. Address filtering, the byte-position rules of short and long frames, the choice between the gain and an offset register, and the routing of the detector output depend on frame history. Only the bench's scenarios can show them, by comparing the outputs against a model of the frame sequence.

// File: rtl/tcr_pkg.sv
package tcr_pkg;

    localparam int BYTE_W = 8;

    typedef struct packed {
        logic       mon;
        logic       mon_ch;
        logic [1:0] srch;
        logic       nr;
        logic       mute;
        logic       head;
        logic       eq;
    } ctrl_t;

    localparam logic [1:0] SRCH_OFF   = 2'b00;
    localparam logic [1:0] SRCH_BLANK = 2'b01;
    localparam logic [1:0] SRCH_LATCH = 2'b10;
    localparam logic [1:0] SRCH_SCAN  = 2'b11;

endpackage

// File: rtl/tcr_frame_seq.sv
module tcr_frame_seq #(
    parameter logic [6:0] DEV_ADDR = 7'h5C
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       frame_start,
    input  logic       byte_valid,
    input  logic [7:0] byte_data,
    output logic       wr_ctrl,
    output logic       wr_code
);
    typedef enum logic [1:0] {
        POS_ADDR = 2'd0,
        POS_CTRL = 2'd1,
        POS_CODE = 2'd2,
        POS_DONE = 2'd3
    } pos_t;

    typedef struct packed {
        pos_t pos;
        logic hit;
    } seq_t;

    seq_t seq_d, seq_q;
    pos_t pos_now;
    logic hit_now;

    always_comb begin
        pos_now = frame_start ? POS_ADDR : seq_q.pos;
        hit_now = frame_start ? 1'b0 : seq_q.hit;
        seq_d   = '{pos: pos_now, hit: hit_now};
        wr_ctrl = 1'b0;
        wr_code = 1'b0;
        if (byte_valid) begin
            unique case (pos_now)
                POS_ADDR: begin
                    seq_d.hit = (byte_data[7:1] == DEV_ADDR) && !byte_data[0];
                    seq_d.pos = POS_CTRL;
                end
                POS_CTRL: begin
                    wr_ctrl   = hit_now;
                    seq_d.pos = POS_CODE;
                end
                POS_CODE: begin
                    wr_code   = hit_now;
                    seq_d.pos = POS_DONE;
                end
                default: seq_d.pos = POS_DONE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= '{pos: POS_DONE, hit: 1'b0};
        else        seq_q <= seq_d;
    end
endmodule

// File: rtl/tcr_mode_guard.sv
module tcr_mode_guard (
    input  logic [1:0] cur_mode,
    input  logic [1:0] req_mode,
    output logic [1:0] new_mode
);
    logic swap;

    always_comb begin
        swap     = cur_mode[1] && req_mode[1] && (cur_mode[0] != req_mode[0]);
        new_mode = swap ? cur_mode : req_mode;
    end
endmodule

// File: rtl/tcr_out_mux.sv
module tcr_out_mux
    import tcr_pkg::*;
(
    input  ctrl_t      ctrl,
    input  logic       head_pin,
    input  logic       head_pin_drv,
    input  logic       eq_pin,
    input  logic       eq_pin_drv,
    input  logic       det_pause,
    input  logic       ofs_cmp_a,
    input  logic       ofs_cmp_b,
    output logic       head_in1,
    output logic       eq_long,
    output logic       nr_en,
    output logic       mute_en,
    output logic [1:0] search_mode,
    output logic       det_out
);
    logic searching;
    logic eq_sel;

    always_comb begin
        searching   = ctrl.srch[1];
        head_in1    = head_pin_drv ? head_pin : ctrl.head;
        eq_sel      = eq_pin_drv ? eq_pin : ctrl.eq;
        eq_long     = eq_sel && !searching;
        nr_en       = ctrl.nr && !searching;
        mute_en     = ctrl.mute;
        search_mode = ctrl.srch;
        if (ctrl.mon) det_out = ctrl.mon_ch ? ofs_cmp_b : ofs_cmp_a;
        else          det_out = det_pause;
    end
endmodule

// File: rtl/tape_ctrl_regs.sv
module tape_ctrl_regs
    import tcr_pkg::*;
#(
    parameter int          CODE_W   = 6,
    parameter logic [6:0]  DEV_ADDR = 7'h5C,
    parameter logic [7:0]  RST_CTRL = 8'h08,
    parameter int          RST_GAIN = 32
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_start,
    input  logic              byte_valid,
    input  logic [7:0]        byte_data,
    input  logic              head_pin,
    input  logic              head_pin_drv,
    input  logic              eq_pin,
    input  logic              eq_pin_drv,
    input  logic              det_pause,
    input  logic              ofs_cmp_a,
    input  logic              ofs_cmp_b,
    output logic              head_in1,
    output logic              eq_long,
    output logic              nr_en,
    output logic              mute_en,
    output logic [1:0]        search_mode,
    output logic [CODE_W-1:0] gain_code,
    output logic [CODE_W-1:0] offset_a,
    output logic [CODE_W-1:0] offset_b,
    output logic              det_out
);
    localparam logic [CODE_W-1:0] GAIN_INIT = CODE_W'(RST_GAIN);

    typedef struct packed {
        ctrl_t             ctrl;
        logic [CODE_W-1:0] gain;
        logic [CODE_W-1:0] offa;
        logic [CODE_W-1:0] offb;
    } regs_t;

    regs_t      regs_d, regs_q;
    logic       wr_ctrl, wr_code;
    logic [1:0] srch_ok;
    ctrl_t      ctrl_in;

    tcr_frame_seq #(.DEV_ADDR(DEV_ADDR)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .frame_start (frame_start),
        .byte_valid  (byte_valid),
        .byte_data   (byte_data),
        .wr_ctrl     (wr_ctrl),
        .wr_code     (wr_code)
    );

    assign ctrl_in = ctrl_t'(byte_data);

    tcr_mode_guard u_guard (
        .cur_mode (regs_q.ctrl.srch),
        .req_mode (ctrl_in.srch),
        .new_mode (srch_ok)
    );

    always_comb begin
        regs_d = regs_q;
        if (wr_ctrl) begin
            regs_d.ctrl      = ctrl_in;
            regs_d.ctrl.srch = srch_ok;
        end
        if (wr_code) begin
            if (!regs_q.ctrl.mon)       regs_d.gain = byte_data[CODE_W-1:0];
            else if (regs_q.ctrl.mon_ch) regs_d.offb = byte_data[CODE_W-1:0];
            else                         regs_d.offa = byte_data[CODE_W-1:0];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= '{ctrl: ctrl_t'(RST_CTRL), gain: GAIN_INIT,
                                offa: '0, offb: '0};
        else        regs_q <= regs_d;
    end

    tcr_out_mux u_mux (
        .ctrl         (regs_q.ctrl),
        .head_pin     (head_pin),
        .head_pin_drv (head_pin_drv),
        .eq_pin       (eq_pin),
        .eq_pin_drv   (eq_pin_drv),
        .det_pause    (det_pause),
        .ofs_cmp_a    (ofs_cmp_a),
        .ofs_cmp_b    (ofs_cmp_b),
        .head_in1     (head_in1),
        .eq_long      (eq_long),
        .nr_en        (nr_en),
        .mute_en      (mute_en),
        .search_mode  (search_mode),
        .det_out      (det_out)
    );

    assign gain_code = regs_q.gain;
    assign offset_a  = regs_q.offa;
    assign offset_b  = regs_q.offb;
endmodule

// File: rtl/tcr_checker.sv
module tcr_checker #(
    parameter int CODE_W = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic              byte_valid,
    input logic              head_pin,
    input logic              head_pin_drv,
    input logic              eq_pin,
    input logic              eq_pin_drv,
    input logic              head_in1,
    input logic              eq_long,
    input logic              nr_en,
    input logic [1:0]        search_mode,
    input logic [CODE_W-1:0] gain_code,
    input logic [CODE_W-1:0] offset_a,
    input logic [CODE_W-1:0] offset_b
);
    // R8
    search_forces_chk: assert property (@(posedge clk) disable iff (!rst_n)
        search_mode[1] |-> (!nr_en && !eq_long));

    // R7
    no_direct_swap_chk: assert property (@(posedge clk) disable iff (!rst_n)
        search_mode[1] |=> (!search_mode[1] || search_mode == $past(search_mode)));

    // R9
    head_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        head_pin_drv |-> (head_in1 == head_pin));

    // R10
    eq_pin_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (eq_pin_drv && !search_mode[1]) |-> (eq_long == eq_pin));

    // R6
    idle_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !byte_valid |=> ($stable(gain_code) && $stable(offset_a)
                         && $stable(offset_b) && $stable(search_mode)));

    // R5
    one_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
        byte_valid |=> ($countones({!$stable(gain_code), !$stable(offset_a),
                                    !$stable(offset_b)}) <= 1));
endmodule

bind tape_ctrl_regs tcr_checker #(.CODE_W(CODE_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .byte_valid   (byte_valid),
    .head_pin     (head_pin),
    .head_pin_drv (head_pin_drv),
    .eq_pin       (eq_pin),
    .eq_pin_drv   (eq_pin_drv),
    .head_in1     (head_in1),
    .eq_long      (eq_long),
    .nr_en        (nr_en),
    .search_mode  (search_mode),
    .gain_code    (gain_code),
    .offset_a     (offset_a),
    .offset_b     (offset_b)
);

// File: tb/tape_ctrl_regs_bench.sv
module tape_ctrl_regs_bench;
    localparam int CLK_PERIOD = 10;
    localparam logic [7:0] ADDR_OK = 8'hB8;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       frame_start = 1'b0, byte_valid = 1'b0;
    logic [7:0] byte_data = '0;
    logic       head_pin = 1'b0, head_pin_drv = 1'b0, eq_pin = 1'b0, eq_pin_drv = 1'b0;
    logic       det_pause = 1'b0, ofs_cmp_a = 1'b0, ofs_cmp_b = 1'b0;
    logic       head_in1, eq_long, nr_en, mute_en, det_out;
    logic [1:0] search_mode;
    logic [5:0] gain_code, offset_a, offset_b;

    int vectors = 0;
    int errors  = 0;
    bit done    = 1'b0;

    logic [7:0] m_ctrl;
    logic [5:0] m_gain, m_offa, m_offb;
    int         m_pos;
    bit         m_hit;

    tape_ctrl_regs u_tape_ctrl_regs (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic cmp(string req, string what, int act, int exp);
        vectors++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    function automatic logic [1:0] guard(logic [1:0] cur, logic [1:0] req);
        if (cur[1] && req[1] && cur[0] != req[0]) return cur;
        return req;
    endfunction

    task automatic check_all(string req);
        logic exp_eq, exp_det;
        #1;
        exp_eq  = m_ctrl[5] ? 1'b0 : (eq_pin_drv ? eq_pin : m_ctrl[0]);
        exp_det = m_ctrl[7] ? (m_ctrl[6] ? ofs_cmp_b : ofs_cmp_a) : det_pause;
        cmp({req, "/R9"},  "head_in1", head_in1, head_pin_drv ? head_pin : m_ctrl[1]);
        cmp({req, "/R10"}, "eq_long", eq_long, exp_eq);
        cmp({req, "/R8"},  "nr_en", nr_en, m_ctrl[3] && !m_ctrl[5]);
        cmp({req, "/R3"},  "mute_en", mute_en, m_ctrl[2]);
        cmp({req, "/R7"},  "search_mode", search_mode, m_ctrl[5:4]);
        cmp({req, "/R4"},  "gain_code", gain_code, m_gain);
        cmp({req, "/R5"},  "offset_a", offset_a, m_offa);
        cmp({req, "/R5"},  "offset_b", offset_b, m_offb);
        cmp({req, "/R11"}, "det_out", det_out, exp_det);
    endtask

    task automatic start_frame();
        @(negedge clk);
        frame_start = 1'b1;
        m_pos = 0;
        m_hit = 1'b0;
        @(negedge clk);
        frame_start = 1'b0;
    endtask

    task automatic send(logic [7:0] b, string req);
        @(negedge clk);
        byte_valid = 1'b1;
        byte_data  = b;
        case (m_pos)
            0: m_hit = (b[7:1] == 7'h5C) && !b[0];
            1: if (m_hit) m_ctrl = {b[7:6], guard(m_ctrl[5:4], b[5:4]), b[3:0]};
            2: if (m_hit) begin
                   if (!m_ctrl[7])     m_gain = b[5:0];
                   else if (m_ctrl[6]) m_offb = b[5:0];
                   else                m_offa = b[5:0];
               end
            default: ;
        endcase
        if (m_pos < 3) m_pos++;
        @(negedge clk);
        byte_valid = 1'b0;
        check_all(req);
    endtask

    task automatic frame3(logic [7:0] c, logic [7:0] d, string req);
        start_frame();
        send(ADDR_OK, req);
        send(c, req);
        send(d, req);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            errors++;
            $display("FAIL watchdog expired");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd1234));
        m_ctrl = 8'h08; m_gain = 6'd32; m_offa = '0; m_offb = '0;
        m_pos = 3; m_hit = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_all("R1");

        // R2: bytes before any frame start do nothing
        send(8'hFF, "R2");
        send(8'h3F, "R2");
        // R2: wrong address and read bit
        start_frame(); send(8'hBA, "R2"); send(8'h0F, "R2"); send(8'h11, "R2");
        start_frame(); send(8'hB9, "R2"); send(8'h0F, "R2"); send(8'h11, "R2");
        // R3, R4: standard frame
        frame3(8'h0B, 8'h15, "R3");
        // R6: extra byte ignored
        send(8'h2A, "R6");
        // R5: offset frames A then B
        frame3(8'h80, 8'h3E, "R5");
        frame3(8'hC0, 8'h21, "R5");
        ofs_cmp_a = 1'b1; check_all("R11");
        ofs_cmp_b = 1'b1; check_all("R11");
        // R6: truncated frame keeps settings byte only
        start_frame(); send(ADDR_OK, "R6"); send(8'h0C, "R6");
        start_frame(); send(ADDR_OK, "R6"); send(8'h0E, "R6");
        // R7: latch then direct scan refused, via blank skip accepted
        frame3(8'h2F, 8'h10, "R7");
        frame3(8'h3F, 8'h11, "R7");
        frame3(8'h1F, 8'h12, "R7");
        frame3(8'h3F, 8'h13, "R7");
        frame3(8'h2F, 8'h14, "R7");
        // R8, R10: pins cannot undo search forcing
        eq_pin_drv = 1'b1; eq_pin = 1'b1; check_all("R8");
        frame3(8'h09, 8'h05, "R10");
        eq_pin = 1'b0; check_all("R10");
        head_pin_drv = 1'b1; head_pin = 1'b1; check_all("R9");
        head_pin = 1'b0; check_all("R9");
        head_pin_drv = 1'b0; eq_pin_drv = 1'b0; check_all("R9");

        // random traffic
        for (int i = 0; i < 600; i++) begin
            int act;
            act = int'($urandom_range(0, 9));
            if (act == 0) start_frame();
            else if (act <= 6) begin
                if (m_pos == 0 && $urandom_range(0, 4) != 0) send(ADDR_OK, "R2");
                else send(8'($urandom), "R3");
            end else begin
                @(negedge clk);
                {head_pin, head_pin_drv, eq_pin, eq_pin_drv,
                 det_pause, ofs_cmp_a, ofs_cmp_b} = 7'($urandom);
                check_all("R11");
            end
        end

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule